// File: doc/BRIEF.md
# Streaming Block Transposer

This block turns the rows of a square block of samples into its columns while the samples stream through it. It suits a separable two-pass transform: the first one-dimensional pass writes rows into this array, and the second pass reads columns out of it. Each accepted beat carries one row of `N` samples and a small mode tag. Each delivered beat carries one column of the same block, together with the tag that arrived with the matching row.

The storage is an `N`×`N` grid of registers. Every cell picks one of three sources: its own value, the cell above it, or the cell to its right. In the downward phase new rows enter at the top and the bottom row leaves. In the leftward phase new rows enter as the rightmost column, with lane `i` placed in grid row `N-1-i`, and the leftmost column leaves. After every `N` accepted rows the phase swaps. The block that has just filled the grid therefore leaves in the crossed orientation while the next block enters behind it.

A history of the last `N` shift slots records, for each slot, whether it held a real row and which mode tag it carried. This history produces the output valid and the output tag.

Both streams use valid/ready. `in_ready` is high unless a valid output is waiting and `out_ready` is low. When that happens, the grid, the history and the output hold still, and no input is taken. The grid moves on a cycle in one of two cases: a row is offered, or no row of the current block has arrived yet. In the second case the grid shifts an empty slot in, so the previous block drains without any new input. If the upstream pauses part-way through a block, the whole grid freezes. While it is frozen `out_valid` is low, even when it was high on the cycle before. `out_valid` depends combinationally on `in_valid`, and `in_ready` depends combinationally on `out_ready`.

Top module: `tp_transpose_array`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1, and no stale row is ever delivered.
- R2: Beat `j` (counting from 0) of a delivered block carries, in lane `i`, lane `j` of input row `i` of that block. Lane `k` of a bus occupies bits `[k*W +: W]`.
- R3: When `out_ready` stays high and the input pauses only at block boundaries, the output beat `k` of the stream is delivered exactly 4 clock cycles after input row `k` was accepted.
- R4: Blocks sent back to back with no idle cycle are each crossed correctly. The shift phase changes after every `N` accepted rows and at no other time.
- R5: Every delivered beat carries on `out_mode` the `in_mode` value that was accepted with the input row of the same index within its block.
- R6: While no row of the current block has been accepted, the grid keeps shifting with `in_valid` low. The previous block is therefore fully delivered without further input.
- R7: When `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_vec` and `out_mode` keep their values on the next cycle.
- R8: When `in_valid` is low part-way through a block, `out_valid` is 0 and nothing moves. After the pause, the block is delivered as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input row offered |
| in_ready | output | 1 | Input row taken on this edge when `in_valid` is also high |
| in_row | input | N*W | Input row, lane k at bits [k*W +: W] |
| in_mode | input | MW | Mode tag for this row |
| out_valid | output | 1 | Output column offered |
| out_ready | input | 1 | Downstream accepts the column |
| out_vec | output | N*W | Output column, lane k at bits [k*W +: W] |
| out_mode | output | MW | Mode tag matching this column |

## Verification
Several internal faults are visible within one block. A phase flag that swaps early or late turns the very next block into rows rather than columns, or mixes two blocks together. A cell that takes the wrong neighbour corrupts a single lane within `N` beats. A history entry that is lost or duplicated shows up as an output beat at the wrong cycle offset, or as a count of delivered beats that differs from the count of accepted rows. A grid that is not frozen during a mid-block pause or an output stall shows up at the ports: as a beat delivered during the pause, or as a change in `out_vec` while it waits.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Source picked by every cell of the grid on a clock edge.
  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_UP    = 2'd1,
    SEL_RIGHT = 2'd2
  } tp_sel_e;

  // Current shift phase of the grid.
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_LEFT = 1'b1
  } tp_dir_e;

endpackage

// File: rtl/tp_cell.sv
module tp_cell #(
  parameter int W = 16
) (
  input  logic             clk,
  input  tp_pkg::tp_sel_e  sel,
  input  logic [W-1:0]     up_d,
  input  logic [W-1:0]     right_d,
  output logic [W-1:0]     q
);
  import tp_pkg::*;

  always_ff @(posedge clk) begin
    case (sel)
      SEL_UP:    q <= up_d;
      SEL_RIGHT: q <= right_d;
      default:   q <= q;
    endcase
  end

endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl #(
  parameter int N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic             slot_valid,
  output logic             feed,
  output logic             advance,
  output logic             accept,
  output logic             in_ready,
  output tp_pkg::tp_dir_e  dir
);
  import tp_pkg::*;

  localparam int CW   = (N > 1) ? $clog2(N) : 1;
  localparam int LAST = N - 1;

  logic [CW-1:0] cnt_q;
  tp_dir_e       dir_q;
  logic          move_ok;
  logic          block_open;
  logic          wrap;

  // A block is open once at least one of its rows is in the grid.
  assign block_open = (cnt_q != '0);
  assign move_ok    = !slot_valid || out_ready;
  assign feed       = in_valid || !block_open;
  assign advance    = feed && move_ok;
  assign accept     = in_valid && move_ok;
  assign in_ready   = move_ok;
  assign wrap       = accept && (cnt_q == CW'(LAST));
  assign dir        = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= DIR_DOWN;
    end else if (accept) begin
      if (cnt_q == CW'(LAST)) begin
        cnt_q <= '0;
        dir_q <= (dir_q == DIR_DOWN) ? DIR_LEFT : DIR_DOWN;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  AST_DIR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (dir_q != $past(dir_q))); // R4
  AST_DIR_STEADY: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(dir_q)); // R4
  AST_PAUSE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (block_open && !in_valid) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/tp_hist.sv
module tp_hist #(
  parameter int N  = 4,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic          accept,
  input  logic [MW-1:0] in_mode,
  output logic          last_valid,
  output logic [MW-1:0] last_mode
);

  logic [N-1:0]         vld_q;
  logic [N-1:0][MW-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      mode_q <= '0;
    end else if (advance) begin
      vld_q[0]  <= accept;
      mode_q[0] <= in_mode;
      for (int i = 1; i < N; i++) begin
        vld_q[i]  <= vld_q[i-1];
        mode_q[i] <= mode_q[i-1];
      end
    end
  end

  assign last_valid = vld_q[N-1];
  assign last_mode  = mode_q[N-1];

  AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !advance |=> ($stable(vld_q) && $stable(mode_q))); // R8

endmodule

// File: rtl/tp_transpose_array.sv
module tp_transpose_array #(
  parameter int N  = 4,
  parameter int W  = 16,
  parameter int MW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [N*W-1:0]  in_row,
  input  logic [MW-1:0]   in_mode,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [N*W-1:0]  out_vec,
  output logic [MW-1:0]   out_mode
);
  import tp_pkg::*;

  localparam int LAST = N - 1;

  logic         feed, advance, accept, slot_valid;
  tp_dir_e      dir;
  tp_sel_e      sel;
  logic [W-1:0] lane_in [N];
  logic [W-1:0] cell_q  [N][N];

  tp_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .slot_valid (slot_valid),
    .feed       (feed),
    .advance    (advance),
    .accept     (accept),
    .in_ready   (in_ready),
    .dir        (dir)
  );

  tp_hist #(.N(N), .MW(MW)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .advance    (advance),
    .accept     (accept),
    .in_mode    (in_mode),
    .last_valid (slot_valid),
    .last_mode  (out_mode)
  );

  always_comb begin
    if (!advance)             sel = SEL_HOLD;
    else if (dir == DIR_DOWN) sel = SEL_UP;
    else                      sel = SEL_RIGHT;
  end

  for (genvar k = 0; k < N; k++) begin : g_lane
    assign lane_in[k] = in_row[k*W +: W];
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic [W-1:0] up_src, right_src;
      if (r == 0) begin : g_top
        assign up_src = lane_in[c];
      end else begin : g_inner_v
        assign up_src = cell_q[r-1][c];
      end
      if (c == LAST) begin : g_edge
        assign right_src = lane_in[LAST-r];
      end else begin : g_inner_h
        assign right_src = cell_q[r][c+1];
      end
      tp_cell #(.W(W)) u_cell (
        .clk     (clk),
        .sel     (sel),
        .up_d    (up_src),
        .right_d (right_src),
        .q       (cell_q[r][c])
      );
    end
  end

  // Down phase: bottom row leaves. Left phase: leftmost column leaves.
  for (genvar k = 0; k < N; k++) begin : g_out
    assign out_vec[k*W +: W] = (dir == DIR_DOWN) ? cell_q[LAST][k]
                                                 : cell_q[LAST-k][0];
  end

  assign out_valid = slot_valid && feed;

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !out_valid); // R1
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_vec) && $stable(out_mode))); // R7
  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R7

endmodule

// File: tb/tp_transpose_array_bench.sv
`timescale 1ns/1ps
module tp_transpose_array_bench;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int MW = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [N*W-1:0]  in_row = '0;
  logic [MW-1:0]   in_mode = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [N*W-1:0]  out_vec;
  logic [MW-1:0]   out_mode;

  tp_transpose_array #(.N(N), .W(W), .MW(MW)) u_tp_transpose_array (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_vec(out_vec), .out_mode(out_mode)
  );

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  int in_idx = 0, out_idx = 0;
  int acc_cyc [0:1023];
  logic [15:0] lfsr = 16'hACE1;
  bit          prev_stall = 0;
  logic [N*W-1:0] prev_vec;
  logic [MW-1:0]  prev_mode;

  function automatic logic [W-1:0] sample_val(int b, int r, int c);
    return W'((b * 4099 + r * 257 + c * 31 + 7) ^ (b * 13 + (r << 12)));
  endfunction

  function automatic logic [MW-1:0] mode_of(int b, int r);
    return MW'((b + 3 * r) % 4);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // One cycle: drive after the falling edge, sample 1 ns later.
  task automatic cycle(bit iv, bit ordy, bit chk_lat, string req);
    @(negedge clk);
    in_valid  = iv;
    out_ready = ordy;
    for (int j = 0; j < N; j++)
      in_row[j*W +: W] = sample_val(in_idx / N, in_idx % N, j);
    in_mode = mode_of(in_idx / N, in_idx % N);
    #1;
    if (prev_stall) begin
      check(out_vec == prev_vec, "R7", "vector held under stall", out_vec, prev_vec);
      check(out_mode == prev_mode, "R7", "mode held under stall", out_mode, prev_mode);
    end
    if (out_valid && !ordy)
      check(in_ready == 1'b0, "R7", "in_ready low under stall", in_ready, 0);
    if (!iv && (in_idx % N) != 0)
      check(out_valid == 1'b0, "R8", "no output during mid-block pause", out_valid, 0);
    if (out_valid && ordy) begin
      logic [N*W-1:0] exp_vec;
      for (int i = 0; i < N; i++)
        exp_vec[i*W +: W] = sample_val(out_idx / N, i, out_idx % N);
      check(out_vec == exp_vec, req, "crossed column", out_vec, exp_vec);
      check(out_mode == mode_of(out_idx / N, out_idx % N), "R5", "mode tag",
            out_mode, mode_of(out_idx / N, out_idx % N));
      if (chk_lat)
        check(cyc - acc_cyc[out_idx % 1024] == 4, "R3", "latency",
              cyc - acc_cyc[out_idx % 1024], 4);
      out_idx++;
    end
    prev_stall = out_valid && !ordy;
    prev_vec   = out_vec;
    prev_mode  = out_mode;
    if (iv && in_ready) begin
      acc_cyc[in_idx % 1024] = cyc;
      in_idx++;
    end
    cyc++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int target;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // Back-to-back blocks, no pauses (R2, R4, R3).
    repeat (8 * N) cycle(1, 1, 1, "R2 R4");

    // Idle gaps only at block boundaries: drain without input (R6).
    for (int g = 1; g <= 6; g++) begin
      repeat (g) cycle(0, 1, 1, "R6");
      repeat (N) cycle(1, 1, 1, "R6");
    end

    // Random pauses inside blocks (R8).
    target = in_idx + 8 * N;
    while (in_idx < target) begin
      lfsr_step();
      cycle(lfsr[0] | lfsr[5], 1, 0, "R8");
    end

    // Random downstream back-pressure (R7).
    target = in_idx + 8 * N;
    while (in_idx < target) begin
      lfsr_step();
      cycle(1, lfsr[1] | lfsr[7], 0, "R7");
    end

    // Both sides random.
    target = in_idx + 8 * N;
    while (in_idx < target) begin
      lfsr_step();
      cycle(lfsr[2] | lfsr[9], lfsr[3] | lfsr[11], 0, "R2");
    end

    // Drain the last block with no input (R6).
    repeat (3 * N) cycle(0, 1, 0, "R6");
    check(out_idx == in_idx, "R6", "all accepted rows delivered", out_idx, in_idx);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule